// File: doc/BRIEF.md
# Multimode General-Purpose Timer

This block is one general-purpose timer. A single counter serves three jobs, chosen by a mode field: generating a pulse-width-modulated waveform, measuring the high time and repetition time of pulses on an input pin, and counting rising edges on that pin as an external clock. Measuring the high time of pulses is how the block finds the bit time of an incoming serial stream for automatic baud-rate detection. In every mode the block raises a one-cycle interrupt request each time a cycle completes. In capture mode, a pulse that never ends sets a sticky error flag.

Software sets `period`, `width` and `mode`, then raises `enable`. The mode is taken when the timer leaves idle. Dropping `enable` returns the timer to idle. The input pin passes through a two-flop synchroniser before it is used, so it may be driven asynchronously.

The controller has six states. Transitions:
- IDLE goes to PWM, CAP_ARM or EXT when the timer is enabled with a non-zero mode.
- CAP_ARM goes to CAP_HIGH on a rising edge.
- CAP_HIGH goes to CAP_LOW on a falling edge.
- CAP_LOW goes to CAP_HIGH on a rising edge, which completes one period.
- CAP_HIGH and CAP_LOW go to CAP_ARM when the counter wraps with no edge.
- Every state goes to IDLE while `enable` is low.

Top module: `gp_timer`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `pin_out`, `irq`, `ovf_err`, `cap_width` and `cap_period` are all 0.
- R2: Mode encoding: 2'b00 is off, 2'b01 is PWM, 2'b10 is capture, 2'b11 is external count. In PWM mode, `pin_out` is high for the first `width` clock cycles of each `period`-cycle frame. It is always high if `width` is at least `period`, and always low if `width` is 0.
- R3: In PWM mode, new `period` and `width` values are taken only at the start of the next frame. The frame in progress keeps its old values.
- R4: In PWM mode, `irq` is high for one cycle at the end of each frame.
- R5: In capture mode, `cap_width` holds the clock cycles from a rising edge on `pin_in` to the following falling edge. `cap_period` holds the clock cycles from that rising edge to the next rising edge. `irq` pulses once for each completed period.
- R6: In capture mode, the first rising edge after entering the mode only starts the measurement: it updates neither capture output and raises no `irq`.
- R7: In capture mode, if the counter reaches its all-ones value and wraps with no input edge, `ovf_err` is set and the timer re-arms. `ovf_err` stays set until `enable` is dropped.
- R8: In external count mode, synchronised rising edges on `pin_in` are counted. `irq` pulses once when the count reaches `period`, and counting then restarts from zero.
- R9: `enable` low returns the timer to idle within one cycle: `pin_out` is low, the counter is cleared and `ovf_err` is cleared. A change of `mode` while enabled has no effect until the next enable.
- R10: A `period` of 0 behaves as 1: every clock cycle (PWM) or every rising edge (external count) ends a frame and pulses `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter advances on it in internal modes |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the timer; low forces idle |
| mode | input | 2 | 00 off, 01 PWM, 10 capture, 11 external count |
| period | input | CNT_W | Frame length (PWM) or edge count per interrupt (external) |
| width | input | CNT_W | High time of the PWM output |
| pin_in | input | 1 | Asynchronous input for capture or external counting |
| pin_out | output | 1 | PWM waveform |
| irq | output | 1 | One-cycle interrupt request per completed cycle |
| cap_width | output | CNT_W | Last measured high time |
| cap_period | output | CNT_W | Last measured rise-to-rise time |
| ovf_err | output | 1 | Sticky capture overflow flag |

## Verification
The hardest state to reach is the capture overflow. The counter must wrap with no input edge, which takes 2^CNT_W cycles, so the bench builds the timer with an 8-bit counter and holds the input low for longer than one wrap. It then sends fresh pulses to show that the flag stays set while the timer re-arms, and drops `enable` to show that the flag clears. The two-flop input delay is reproduced in the bench's reference model, so every capture value and interrupt is compared on the exact cycle it appears.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWM,
        ST_CAP_ARM,
        ST_CAP_HIGH,
        ST_CAP_LOW,
        ST_EXT
    } gpt_state_t;

    localparam logic [1:0] MODE_OFF = 2'b00;
    localparam logic [1:0] MODE_PWM = 2'b01;
    localparam logic [1:0] MODE_CAP = 2'b10;
    localparam logic [1:0] MODE_EXT = 2'b11;

endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[LAST];
        end
    end

    assign rise = chain[LAST] & ~prev;
    assign fall = ~chain[LAST] & prev;
endmodule

// File: rtl/gpt_core.sv
module gpt_core
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] width,
    input  logic             in_rise,
    input  logic             in_fall,
    output logic             pin_out,
    output logic             irq,
    output logic [CNT_W-1:0] cap_width,
    output logic [CNT_W-1:0] cap_period,
    output logic             ovf_err
);
    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    gpt_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt, per_l, wid_l;
    logic [CNT_W:0]   cnt_ext;
    logic             cnt_max, frame_end;

    assign cnt_ext   = {1'b0, cnt} + ONE;
    assign cnt_max   = &cnt;
    assign frame_end = cnt_ext >= {1'b0, per_l};

    // next-state selection
    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    unique case (mode)
                        MODE_PWM: state_nx = ST_PWM;
                        MODE_CAP: state_nx = ST_CAP_ARM;
                        MODE_EXT: state_nx = ST_EXT;
                        default:  state_nx = ST_IDLE;
                    endcase
                end
                ST_PWM:      state_nx = ST_PWM;
                ST_CAP_ARM:  if (in_rise) state_nx = ST_CAP_HIGH;
                ST_CAP_HIGH: begin
                    if (in_fall)      state_nx = ST_CAP_LOW;
                    else if (cnt_max) state_nx = ST_CAP_ARM;
                end
                ST_CAP_LOW: begin
                    if (in_rise)      state_nx = ST_CAP_HIGH;
                    else if (cnt_max) state_nx = ST_CAP_ARM;
                end
                ST_EXT:      state_nx = ST_EXT;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // counter, latched settings and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            per_l      <= '0;
            wid_l      <= '0;
            irq        <= 1'b0;
            cap_width  <= '0;
            cap_period <= '0;
            ovf_err    <= 1'b0;
        end else if (!enable) begin
            cnt     <= '0;
            irq     <= 1'b0;
            ovf_err <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    cnt   <= '0;
                    per_l <= period;
                    wid_l <= width;
                end
                ST_PWM: begin
                    if (frame_end) begin
                        cnt   <= '0;
                        per_l <= period;
                        wid_l <= width;
                        irq   <= 1'b1;
                    end else begin
                        cnt <= cnt_ext[CNT_W-1:0];
                    end
                end
                ST_CAP_ARM: cnt <= '0;
                ST_CAP_HIGH: begin
                    if (in_fall) begin
                        cap_width <= cnt_ext[CNT_W-1:0];
                        cnt       <= cnt_ext[CNT_W-1:0];
                    end else if (cnt_max) begin
                        ovf_err <= 1'b1;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt_ext[CNT_W-1:0];
                    end
                end
                ST_CAP_LOW: begin
                    if (in_rise) begin
                        cap_period <= cnt_ext[CNT_W-1:0];
                        cnt        <= '0;
                        irq        <= 1'b1;
                    end else if (cnt_max) begin
                        ovf_err <= 1'b1;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt_ext[CNT_W-1:0];
                    end
                end
                ST_EXT: begin
                    if (in_rise) begin
                        if (frame_end) begin
                            cnt   <= '0;
                            per_l <= period;
                            irq   <= 1'b1;
                        end else begin
                            cnt <= cnt_ext[CNT_W-1:0];
                        end
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign pin_out = (state == ST_PWM) && (cnt < wid_l);

    // R9
    idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_IDLE && cnt == '0 && !pin_out));

    // R3
    pwm_hold_settings_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_PWM && !frame_end) |=> ($stable(per_l) && $stable(wid_l)));

    // R6
    arm_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAP_ARM) |=> !irq);

    // R7
    ovf_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_err) |-> $past(cnt_max));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && enable) |=> ovf_err);

    // R8
    ext_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXT && per_l != '0) |-> (cnt < per_l));
endmodule

// File: rtl/gp_timer.sv
module gp_timer #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] width,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             irq,
    output logic [CNT_W-1:0] cap_width,
    output logic [CNT_W-1:0] cap_period,
    output logic             ovf_err
);
    logic in_rise, in_fall;

    gpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_in),
        .rise (in_rise),
        .fall (in_fall)
    );

    gpt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .mode      (mode),
        .period    (period),
        .width     (width),
        .in_rise   (in_rise),
        .in_fall   (in_fall),
        .pin_out   (pin_out),
        .irq       (irq),
        .cap_width (cap_width),
        .cap_period(cap_period),
        .ovf_err   (ovf_err)
    );
endmodule

// File: tb/gp_timer_bench.sv
module gp_timer_bench;
    localparam int W   = 8;
    localparam int MAX = 255;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] period = '0;
    logic [W-1:0] width = '0;
    logic         pin_in = 1'b0;
    logic         pin_out, irq, ovf_err;
    logic [W-1:0] cap_width, cap_period;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int hi_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gp_timer #(.CNT_W(W)) u_gp_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .period(period), .width(width), .pin_in(pin_in),
        .pin_out(pin_out), .irq(irq), .cap_width(cap_width),
        .cap_period(cap_period), .ovf_err(ovf_err)
    );

    // behavioural reference: phase 0 idle,1 pwm,2 arm,3 high,4 low,5 ext
    int m_ph, m_cnt, m_per, m_wid, m_cw, m_cp;
    bit m_irq, m_ovf;
    bit pd0, pd1, pd2;

    always @(posedge clk) begin
        bit r, f;
        r = pd1 && !pd2;
        f = !pd1 && pd2;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_per = 0; m_wid = 0; m_cw = 0; m_cp = 0;
            m_irq = 0; m_ovf = 0;
        end else if (!enable) begin
            m_ph = 0; m_cnt = 0; m_irq = 0; m_ovf = 0;
        end else begin
            m_irq = 0;
            case (m_ph)
                0: begin
                    m_cnt = 0; m_per = period; m_wid = width;
                    m_ph = (mode == 2'b01) ? 1 : (mode == 2'b10) ? 2 : (mode == 2'b11) ? 5 : 0;
                end
                1: if (m_cnt + 1 >= m_per) begin
                       m_cnt = 0; m_per = period; m_wid = width; m_irq = 1;
                   end else m_cnt++;
                2: begin m_cnt = 0; if (r) m_ph = 3; end
                3: if (f) begin m_cw = (m_cnt + 1) & MAX; m_cnt = (m_cnt + 1) & MAX; m_ph = 4; end
                   else if (m_cnt == MAX) begin m_ovf = 1; m_cnt = 0; m_ph = 2; end
                   else m_cnt++;
                4: if (r) begin m_cp = (m_cnt + 1) & MAX; m_cnt = 0; m_irq = 1; m_ph = 3; end
                   else if (m_cnt == MAX) begin m_ovf = 1; m_cnt = 0; m_ph = 2; end
                   else m_cnt++;
                5: if (r) begin
                       if (m_cnt + 1 >= m_per) begin m_cnt = 0; m_per = period; m_irq = 1; end
                       else m_cnt++;
                   end
                default: m_ph = 0;
            endcase
        end
        pd2 = rst_n ? pd1 : 1'b0;
        pd1 = rst_n ? pd0 : 1'b0;
        pd0 = rst_n ? pin_in : 1'b0;
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 pin_out", pin_out, (m_ph == 1 && m_cnt < m_wid) ? 1 : 0);
            check("R4 irq", irq, m_irq);
            check("R5 cap_width", cap_width, m_cw);
            check("R5 cap_period", cap_period, m_cp);
            check("R7 ovf_err", ovf_err, m_ovf);
            if (irq) irq_cnt++;
            if (pin_out) hi_cnt++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        pin_in = 1'b1; cyc(hi);
        pin_in = 1'b0; cyc(lo);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired before the end of the run");
        finish_run();
    end

    initial begin
        cyc(3);
        // R1 reset state
        check("R1 pin_out in reset", pin_out, 0);
        check("R1 irq in reset", irq, 0);
        check("R1 ovf_err in reset", ovf_err, 0);
        check("R1 cap_width in reset", cap_width, 0);
        rst_n = 1'b1;
        cyc(2);
        check("R1 cap_period after reset", cap_period, 0);
        check("R1 pin_out after reset", pin_out, 0);

        // R2 PWM, period 5 width 2
        period = 5; width = 2; mode = 2'b01; enable = 1'b1;
        cyc(4);
        hi_cnt = 0; irq_cnt = 0; cyc(50);
        check("R2 high cycles in 10 frames", hi_cnt, 20);
        check("R4 irq per frame", irq_cnt, 10);

        // R9 mode change while running is ignored
        mode = 2'b11;
        hi_cnt = 0; cyc(50);
        check("R9 mode change ignored", hi_cnt, 20);

        // R3 new settings mid-frame, then width >= period
        cyc(2); period = 4; width = 3; cyc(17);
        period = 3; width = 7; cyc(8);
        hi_cnt = 0; cyc(12);
        check("R2 width>=period always high", hi_cnt, 12);
        width = 0; cyc(8);
        hi_cnt = 0; cyc(12);
        check("R2 width 0 always low", hi_cnt, 0);

        // R10 period 0 in PWM
        period = 0; cyc(8);
        irq_cnt = 0; cyc(10);
        check("R10 period 0 irq each cycle", irq_cnt, 10);

        // R9 disable
        enable = 1'b0; cyc(1);
        check("R9 pin_out low when disabled", pin_out, 0);
        irq_cnt = 0; cyc(5);
        check("R9 no irq when disabled", irq_cnt, 0);

        // R5 R6 capture
        mode = 2'b10; enable = 1'b1; cyc(3);
        irq_cnt = 0;
        repeat (5) pulse(7, 5);
        pin_in = 1'b1; cyc(3); pin_in = 1'b0; cyc(6);
        check("R5 cap_width", cap_width, 3);
        check("R5 cap_period", cap_period, 12);
        check("R6 first rise only arms", irq_cnt, 5);
        repeat (3) pulse(2, 9);
        check("R5 short pulse width", cap_width, 2);
        check("R5 short pulse period", cap_period, 11);

        // R7 overflow
        cyc(300);
        check("R7 ovf_err set after wrap", ovf_err, 1);
        repeat (3) pulse(4, 4);
        check("R7 ovf_err sticky", ovf_err, 1);
        check("R7 re-armed capture", cap_period, 8);
        enable = 1'b0; cyc(2);
        check("R7 ovf_err cleared by disable", ovf_err, 0);

        // R8 external counting, period 3
        period = 3; mode = 2'b11; enable = 1'b1; cyc(3);
        irq_cnt = 0;
        repeat (7) pulse(2, 2);
        cyc(4);
        check("R8 irq per 3 edges", irq_cnt, 2);
        irq_cnt = 0;
        repeat (6) pulse(1, 1);
        cyc(4);
        check("R8 fast edges counted", irq_cnt, 2);

        // R10 period 0 in external mode (new period taken at frame end)
        period = 0;
        repeat (3) pulse(2, 2);
        cyc(4);
        irq_cnt = 0;
        repeat (4) pulse(2, 2);
        cyc(4);
        check("R10 period 0 irq per edge", irq_cnt, 4);

        enable = 1'b0; cyc(3);
        finish_run();
    end
endmodule